// File: doc/BRIEF.md
# Transceiver Reconfiguration Request Streamer

This block is a memory-mapped control slave that sits between software and the register bus of a group of serial transceiver channels. Software loads a logical channel number, a register offset and a data word. It then writes the control register with a mode and a start bit. The block translates the logical channel into a physical channel and checks that the request is legal. It then performs the transfer on the back-end bus while it reports busy, and it flags an error for any request it rejects.

Two modes exist. In direct-write mode the block reads the target back-end register first. It then writes back a merge in which calibration-protected bit fields keep their old value and all other bits take the new data. In memory-file mode it walks a small internal table of offset/data records from record 0. It writes each record unmasked to the selected physical channel and stops at the first record whose offset is all ones. That end-marker record is never written.

Top module: `xrs_streamer`

## Requirements
- R1: The logical channel register at word address 0x38 holds bits [9:0]. It can be read and written, and bits [31:10] read as zero.
- R2: The control register sits at 0x3A. Bit 9 is the error flag and bit 8 is the busy flag, and both are read-only. Bits [3:2] are the mode field, which can be read and written. Bit 0 is the start bit, which always reads 0. All other bits read 0 and ignore writes, and any unmapped address reads 0.
- R3: The offset register at 0x3B holds bits [7:0] and the data register at 0x3C holds bits [15:0]. Both can be read and written, and their other bits read as zero.
- R4: A start is a control write with bit 0 set. A start that is accepted while the block is idle raises busy in the next cycle. Busy stays high until the last back-end transfer has completed. The back end holds be_req until it receives a one-cycle be_ack.
- R5: A start issued while busy is ignored: the running operation completes unchanged and no extra back-end transfer occurs.
- R6: Logical channel L maps to physical channel L+2. The back-end address is {physical[5:0], offset[7:0]}. Direct-write mode (mode 2'b01) does exactly one read of that address followed by one write to it.
- R7: Direct-write data is merged as (old & mask) | (new & ~mask). The protect masks are 0x00F0 at offset 0x10, 0x0F00 at 0x11, 0x000C at 0x12 and 0xC000 at 0x13, and 0 at all other offsets.
- R8: A logical channel of 12 or more sets the error flag and causes no back-end transfer.
- R9: A logical channel whose physical channel is 13 or more (logical 11) sets the error flag and causes no back-end transfer.
- R10: In direct-write mode, an offset of 0x40 or more sets the error flag and causes no back-end transfer.
- R11: A start with a reserved mode (2'b10 or 2'b11) sets the error flag, causes no transfer and does not raise busy.
- R12: The error flag holds until the next accepted start, which clears it.
- R13: Memory-file mode (mode 2'b00) writes records i = 0, 1, 2 with offset 0x20+i and data 0xA500+i to the mapped physical channel. It does no reads and no masking, and it stops at the end-marker record (offset 0xFF) without writing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 7 | Control word address |
| cfg_wr | input | 1 | Control write strobe |
| cfg_wdata | input | 32 | Control write data |
| cfg_rdata | output | 32 | Control read data for cfg_addr (combinational) |
| be_req | output | 1 | Back-end request, held until acknowledged |
| be_we | output | 1 | Back-end write (1) or read (0) |
| be_addr | output | 14 | Back-end address {physical channel, offset} |
| be_wdata | output | 16 | Back-end write data |
| be_rdata | input | 16 | Back-end read data, valid with be_ack |
| be_ack | input | 1 | Back-end one-cycle completion |

## Verification
The bench preloads back-end registers with all ones and with mixed patterns, then performs direct writes to each class of offset. A design that inverted or skipped the protect mask would either clobber the calibration bits or drop the new data, and the stored value would differ. Logical channel 11 targets the one case where the channel is legal but its physical channel is not. Offset 0x40 and the reserved modes target the other rejection rules. A design that still issued transfers after flagging an error shows up in the read and write counts of the back-end model. A second start fired during a memory-file run, together with the unwritten end-marker slot, would expose an engine that restarts, runs past the marker or writes it.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
   localparam int CFG_AW = 7;
   localparam int CFG_DW = 32;

   localparam logic [CFG_AW-1:0] A_LCH  = 7'h38;
   localparam logic [CFG_AW-1:0] A_CTRL = 7'h3A;
   localparam logic [CFG_AW-1:0] A_OFS  = 7'h3B;
   localparam logic [CFG_AW-1:0] A_DATA = 7'h3C;

   localparam int B_ERR   = 9;
   localparam int B_BUSY  = 8;
   localparam int B_START = 0;
   localparam int B_MODE  = 2;

   typedef enum logic [1:0] {
      MODE_MIF    = 2'b00,
      MODE_DIRECT = 2'b01,
      MODE_RSV2   = 2'b10,
      MODE_RSV3   = 2'b11
   } xrs_mode_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DW_RD,
      S_DW_WR,
      S_MIF_FETCH,
      S_MIF_WR
   } xrs_state_e;
endpackage

// File: rtl/xrs_chan_map.sv
module xrs_chan_map #(
   parameter int LCH_W     = 10,
   parameter int PHYS_W    = 6,
   parameter int NUM_LCH   = 12,
   parameter int NUM_PCH   = 13,
   parameter int PHYS_BASE = 2,
   parameter int REVERSE   = 0
) (
   input  logic [LCH_W-1:0]  lch_i,
   output logic [PHYS_W-1:0] phys_o,
   output logic              lch_ok_o,
   output logic              phys_ok_o
);
   if (NUM_PCH > (1 << PHYS_W)) begin : g_bad_pch
      $error("xrs_chan_map: NUM_PCH does not fit PHYS_W");
   end
   if (NUM_LCH > (1 << LCH_W)) begin : g_bad_lch
      $error("xrs_chan_map: NUM_LCH does not fit LCH_W");
   end

   int target;

   if (REVERSE != 0) begin : g_rev
      assign target = PHYS_BASE + NUM_LCH - 1 - int'(lch_i);
   end else begin : g_fwd
      assign target = PHYS_BASE + int'(lch_i);
   end

   always_comb begin
      lch_ok_o  = int'(lch_i) < NUM_LCH;
      phys_ok_o = lch_ok_o && (target >= 0) && (target < NUM_PCH);
      phys_o    = PHYS_W'(target);
   end
endmodule

// File: rtl/xrs_prot_mask.sv
module xrs_prot_mask #(
   parameter int OFS_W     = 8,
   parameter int DATA_W    = 16,
   parameter int PROT_BASE = 'h10
) (
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [DATA_W-1:0] mask_o
);
   localparam int NUM_PROT = 4;

   if (DATA_W < 16) begin : g_bad_w
      $error("xrs_prot_mask: DATA_W must be at least 16");
   end

   function automatic logic [15:0] field_of(input int k);
      case (k)
         0:       return 16'h00F0;
         1:       return 16'h0F00;
         2:       return 16'h000C;
         default: return 16'hC000;
      endcase
   endfunction

   logic [DATA_W-1:0] part [NUM_PROT];

   for (genvar k = 0; k < NUM_PROT; k++) begin : g_fld
      assign part[k] = (ofs_i == OFS_W'(PROT_BASE + k)) ? DATA_W'(field_of(k)) : '0;
   end

   always_comb begin
      mask_o = '0;
      for (int k = 0; k < NUM_PROT; k++) mask_o = mask_o | part[k];
   end
endmodule

// File: rtl/xrs_mif_rom.sv
module xrs_mif_rom #(
   parameter int OFS_W     = 8,
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 8,
   parameter int AW        = $clog2(DEPTH),
   parameter int NUM_REC   = 3,
   parameter int OFS_BASE  = 'h20,
   parameter int DATA_BASE = 'hA500
) (
   input  logic [AW-1:0]     ptr_i,
   output logic [OFS_W-1:0]  ofs_o,
   output logic [DATA_W-1:0] data_o
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("xrs_mif_rom: DEPTH must be a power of two");
   end
   if (NUM_REC >= DEPTH) begin : g_bad_rec
      $error("xrs_mif_rom: no room for the end marker");
   end

   logic [OFS_W-1:0]  rec_ofs  [DEPTH];
   logic [DATA_W-1:0] rec_data [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_rec
      if (i < NUM_REC) begin : g_body
         assign rec_ofs[i]  = OFS_W'(OFS_BASE + i);
         assign rec_data[i] = DATA_W'(DATA_BASE + i);
      end else begin : g_end
         assign rec_ofs[i]  = '1;
         assign rec_data[i] = '0;
      end
   end

   assign ofs_o  = rec_ofs[ptr_i];
   assign data_o = rec_data[ptr_i];
endmodule

// File: rtl/xrs_engine.sv
module xrs_engine
   import xrs_pkg::*;
#(
   parameter int LCH_W       = 10,
   parameter int PHYS_W      = 6,
   parameter int OFS_W       = 8,
   parameter int DATA_W      = 16,
   parameter int NUM_LCH     = 12,
   parameter int NUM_PCH     = 13,
   parameter int PHYS_BASE   = 2,
   parameter int NUM_OFS     = 64,
   parameter int MIF_DEPTH   = 8,
   parameter int MIF_RECS    = 3,
   parameter int MAP_REVERSE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [1:0]              mode_i,
   input  logic [LCH_W-1:0]        lch_i,
   input  logic [OFS_W-1:0]        ofs_i,
   input  logic [DATA_W-1:0]       data_i,
   output logic                    busy_o,
   output logic                    err_o,
   output logic                    be_req_o,
   output logic                    be_we_o,
   output logic [PHYS_W+OFS_W-1:0] be_addr_o,
   output logic [DATA_W-1:0]       be_wdata_o,
   input  logic [DATA_W-1:0]       be_rdata_i,
   input  logic                    be_ack_i
);
   localparam int ROM_AW = $clog2(MIF_DEPTH);
   localparam logic [ROM_AW-1:0] PTR_LAST = ROM_AW'(MIF_DEPTH - 1);

   if (NUM_OFS > (1 << OFS_W)) begin : g_bad_ofs
      $error("xrs_engine: NUM_OFS does not fit OFS_W");
   end

   xrs_state_e        state_q;
   logic [PHYS_W-1:0] phys_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DATA_W-1:0] data_q, old_q, mask_q;
   logic [ROM_AW-1:0] ptr_q;
   logic              err_q;

   logic [PHYS_W-1:0] map_phys;
   logic              lch_ok, phys_ok;
   logic [DATA_W-1:0] prot;
   logic [OFS_W-1:0]  rom_ofs;
   logic [DATA_W-1:0] rom_data;
   logic              req_bad;

   xrs_chan_map #(
      .LCH_W(LCH_W), .PHYS_W(PHYS_W), .NUM_LCH(NUM_LCH), .NUM_PCH(NUM_PCH),
      .PHYS_BASE(PHYS_BASE), .REVERSE(MAP_REVERSE)
   ) map_i (
      .lch_i(lch_i), .phys_o(map_phys), .lch_ok_o(lch_ok), .phys_ok_o(phys_ok)
   );

   xrs_prot_mask #(.OFS_W(OFS_W), .DATA_W(DATA_W)) mask_i (
      .ofs_i(ofs_i), .mask_o(prot)
   );

   xrs_mif_rom #(
      .OFS_W(OFS_W), .DATA_W(DATA_W), .DEPTH(MIF_DEPTH), .AW(ROM_AW), .NUM_REC(MIF_RECS)
   ) rom_i (
      .ptr_i(ptr_q), .ofs_o(rom_ofs), .data_o(rom_data)
   );

   always_comb begin
      req_bad = mode_i[1] || !lch_ok || !phys_ok ||
                ((mode_i == MODE_DIRECT) && (int'(ofs_i) >= NUM_OFS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         phys_q  <= '0;
         ofs_q   <= '0;
         data_q  <= '0;
         old_q   <= '0;
         mask_q  <= '0;
         ptr_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: if (start_i) begin
               err_q  <= req_bad;
               phys_q <= map_phys;
               ofs_q  <= ofs_i;
               data_q <= data_i;
               mask_q <= prot;
               ptr_q  <= '0;
               if (!req_bad)
                  state_q <= (mode_i == MODE_DIRECT) ? S_DW_RD : S_MIF_FETCH;
            end
            S_DW_RD: if (be_ack_i) begin
               old_q   <= be_rdata_i;
               state_q <= S_DW_WR;
            end
            S_DW_WR: if (be_ack_i) state_q <= S_IDLE;
            S_MIF_FETCH: begin
               if (rom_ofs == '1) begin
                  state_q <= S_IDLE;
               end else if (int'(rom_ofs) >= NUM_OFS) begin
                  err_q   <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  state_q <= S_MIF_WR;
               end
            end
            S_MIF_WR: if (be_ack_i) begin
               if (ptr_q == PTR_LAST) begin
                  state_q <= S_IDLE;
               end else begin
                  ptr_q   <= ptr_q + 1'b1;
                  state_q <= S_MIF_FETCH;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      be_req_o   = 1'b0;
      be_we_o    = 1'b0;
      be_addr_o  = {phys_q, ofs_q};
      be_wdata_o = '0;
      case (state_q)
         S_DW_RD: be_req_o = 1'b1;
         S_DW_WR: begin
            be_req_o   = 1'b1;
            be_we_o    = 1'b1;
            be_wdata_o = (old_q & mask_q) | (data_q & ~mask_q);
         end
         S_MIF_WR: begin
            be_req_o   = 1'b1;
            be_we_o    = 1'b1;
            be_addr_o  = {phys_q, rom_ofs};
            be_wdata_o = rom_data;
         end
         default: ;
      endcase
   end

   assign busy_o = (state_q != S_IDLE);
   assign err_o  = err_q;

   // R4: back-end traffic only while busy is reported
   p_req_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      be_req_o |-> busy_o);

   // R5: a start during an operation does not relatch the target channel
   p_ignore_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(phys_q));

   // R7: protected bits of the write equal those read back from the back end
   p_keep_protected_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DW_RD && be_ack_i) |=> ((be_wdata_o & mask_q) == ($past(be_rdata_i) & mask_q)));

   // R8: a rejected request leaves the back end untouched
   p_err_no_traffic_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> !be_req_o);

   // R12: an accepted clean start clears the error flag
   p_err_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !req_bad) |=> !err_o);

   // R13: the end-marker offset never reaches the back end as a write
   p_no_marker_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req_o && be_we_o && state_q == S_MIF_WR) |-> (be_addr_o[OFS_W-1:0] != '1));
endmodule

// File: rtl/xrs_streamer.sv
module xrs_streamer
   import xrs_pkg::*;
#(
   parameter int LCH_W       = 10,
   parameter int PHYS_W      = 6,
   parameter int OFS_W       = 8,
   parameter int DATA_W      = 16,
   parameter int NUM_LCH     = 12,
   parameter int NUM_PCH     = 13,
   parameter int PHYS_BASE   = 2,
   parameter int NUM_OFS     = 64,
   parameter int MIF_DEPTH   = 8,
   parameter int MIF_RECS    = 3,
   parameter int MAP_REVERSE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [6:0]              cfg_addr,
   input  logic                    cfg_wr,
   input  logic [31:0]             cfg_wdata,
   output logic [31:0]             cfg_rdata,
   output logic                    be_req,
   output logic                    be_we,
   output logic [PHYS_W+OFS_W-1:0] be_addr,
   output logic [DATA_W-1:0]       be_wdata,
   input  logic [DATA_W-1:0]       be_rdata,
   input  logic                    be_ack
);
   if (DATA_W > CFG_DW || LCH_W > DATA_W || OFS_W > DATA_W || DATA_W < 16) begin : g_bad_w
      $error("xrs_streamer: field widths do not fit the control word");
   end

   logic [LCH_W-1:0]  lch_q;
   logic [1:0]        mode_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DATA_W-1:0] data_q;
   logic              busy, err, start;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^cfg_wdata[CFG_DW-1:DATA_W];
   assign start = cfg_wr && (cfg_addr == A_CTRL) && cfg_wdata[B_START];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lch_q  <= '0;
         mode_q <= '0;
         ofs_q  <= '0;
         data_q <= '0;
      end else if (cfg_wr) begin
         case (cfg_addr)
            A_LCH:  lch_q  <= cfg_wdata[LCH_W-1:0];
            A_CTRL: mode_q <= cfg_wdata[B_MODE+1:B_MODE];
            A_OFS:  ofs_q  <= cfg_wdata[OFS_W-1:0];
            A_DATA: data_q <= cfg_wdata[DATA_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         A_LCH:  cfg_rdata[LCH_W-1:0] = lch_q;
         A_CTRL: begin
            cfg_rdata[B_ERR]             = err;
            cfg_rdata[B_BUSY]            = busy;
            cfg_rdata[B_MODE+1:B_MODE]   = mode_q;
         end
         A_OFS:  cfg_rdata[OFS_W-1:0]  = ofs_q;
         A_DATA: cfg_rdata[DATA_W-1:0] = data_q;
         default: ;
      endcase
   end

   xrs_engine #(
      .LCH_W(LCH_W), .PHYS_W(PHYS_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
      .NUM_LCH(NUM_LCH), .NUM_PCH(NUM_PCH), .PHYS_BASE(PHYS_BASE), .NUM_OFS(NUM_OFS),
      .MIF_DEPTH(MIF_DEPTH), .MIF_RECS(MIF_RECS), .MAP_REVERSE(MAP_REVERSE)
   ) eng_i (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .mode_i(cfg_wdata[B_MODE+1:B_MODE]),
      .lch_i(lch_q), .ofs_i(ofs_q), .data_i(data_q),
      .busy_o(busy), .err_o(err),
      .be_req_o(be_req), .be_we_o(be_we), .be_addr_o(be_addr),
      .be_wdata_o(be_wdata), .be_rdata_i(be_rdata), .be_ack_i(be_ack)
   );

   // R2: the mode field changes only through a control write
   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == A_CTRL) |=> $stable(mode_q));

   // R1: the channel register is not disturbed by writes elsewhere
   p_lch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == A_LCH) |=> $stable(lch_q));

   // R11: a reserved-mode start never makes the block busy
   p_rsv_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cfg_wdata[B_MODE+1]) |=> !busy);
endmodule

// File: tb/xrs_streamer_tb_top.sv
module xrs_streamer_tb_top;
   localparam int CLK_P = 10;
   localparam logic [6:0] A_LCH = 7'h38, A_CTRL = 7'h3A, A_OFS = 7'h3B, A_DATA = 7'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        be_req, be_we, be_ack;
   logic [13:0] be_addr;
   logic [15:0] be_wdata, be_rdata;

   int n_chk = 0, n_fail = 0;
   int rd_cnt = 0, wr_cnt = 0;
   logic [15:0] mem [0:16383];

   always #(CLK_P/2) clk = ~clk;

   xrs_streamer dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .be_req(be_req), .be_we(be_we),
      .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata), .be_ack(be_ack)
   );

   // back-end register model: one-cycle acknowledge per request
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_ack   <= 1'b0;
         be_rdata <= '0;
      end else if (be_req && !be_ack) begin
         be_ack <= 1'b1;
         if (be_we) begin
            mem[be_addr] <= be_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            be_rdata <= mem[be_addr];
            rd_cnt <= rd_cnt + 1;
         end
      end else begin
         be_ack <= 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_now(input logic [6:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 200; i++) begin
         rd_now(A_CTRL, s);
         if (!s[8]) break;
         @(negedge clk);
      end
   endtask

   task automatic setup(input int lch, input int ofs, input int data);
      cfg_write(A_LCH, lch);
      cfg_write(A_OFS, ofs);
      cfg_write(A_DATA, data);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd_now(A_CTRL, d); chk("R2 reset status", d, 32'h0);
      rd_now(A_LCH, d);  chk("R1 reset channel", d, 32'h0);
      chk("R4 reset no request", {31'h0, be_req}, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      cfg_write(A_LCH, 32'hFFFF_FFFF);
      rd_now(A_LCH, d); chk("R1 channel width", d, 32'h3FF);
      cfg_write(A_OFS, 32'hFFFF_FFFF);
      rd_now(A_OFS, d); chk("R3 offset width", d, 32'hFF);
      cfg_write(A_DATA, 32'hFFFF_FFFF);
      rd_now(A_DATA, d); chk("R3 data width", d, 32'hFFFF);
      cfg_write(A_CTRL, 32'hFFFF_FFF2);
      rd_now(A_CTRL, d); chk("R2 reserved bits ignored", d, 32'h0);
      cfg_write(A_CTRL, 32'h0000_0008);
      rd_now(A_CTRL, d); chk("R2 mode readback", d, 32'h8);
      rd_now(7'h39, d); chk("R2 unmapped reads zero", d, 32'h0);
   endtask

   task automatic t_direct_masked();
      logic [31:0] d;
      int r0, w0;
      mem[14'h510] = 16'hFFFF;
      setup(3, 'h10, 'h0000);
      r0 = rd_cnt; w0 = wr_cnt;
      cfg_write(A_CTRL, 32'h5);
      rd_now(A_CTRL, d); chk("R4 busy after start", d, 32'h104);
      wait_idle();
      rd_now(A_CTRL, d); chk("R4 idle after op", d, 32'h4);
      chk("R7 DFE field kept", mem[14'h510], 16'h00F0);
      chk("R6 one read one write", rd_cnt - r0 + 16 * (wr_cnt - w0), 17);
      mem[14'h511] = 16'h1234;
      setup(3, 'h11, 'hABCD);
      cfg_write(A_CTRL, 32'h5);
      wait_idle();
      chk("R7 buffer offset field kept", mem[14'h511], 16'hA2CD);
   endtask

   task automatic t_direct_plain();
      mem[14'h905] = 16'h5555;
      setup(7, 'h05, 'h1357);
      cfg_write(A_CTRL, 32'h5);
      wait_idle();
      chk("R6 unprotected offset full write", mem[14'h905], 16'h1357);
   endtask

   task automatic t_error(input string req, input int lch, input int ofs, input logic [31:0] ctl,
                          input logic [31:0] exp_st);
      logic [31:0] d;
      int r0, w0;
      setup(lch, ofs, 'h1111);
      r0 = rd_cnt; w0 = wr_cnt;
      cfg_write(A_CTRL, ctl);
      rd_now(A_CTRL, d); chk({req, " error status"}, d, exp_st);
      repeat (6) @(negedge clk);
      chk({req, " no back-end traffic"}, (rd_cnt - r0) + (wr_cnt - w0), 0);
   endtask

   task automatic t_err_clear();
      logic [31:0] d;
      setup(1, 'h05, 'h2222);
      cfg_write(A_CTRL, 32'h5);
      wait_idle();
      rd_now(A_CTRL, d); chk("R12 error cleared by accepted start", d, 32'h4);
   endtask

   task automatic t_mif();
      logic [31:0] d;
      int r0, w0;
      mem[14'h2FF] = 16'h0000;
      setup(0, 'h05, 'h0);
      r0 = rd_cnt; w0 = wr_cnt;
      cfg_write(A_CTRL, 32'h1);
      wait_idle();
      rd_now(A_CTRL, d); chk("R13 memory-file done status", d, 32'h0);
      chk("R13 record 0", mem[14'h220], 16'hA500);
      chk("R13 record 1", mem[14'h221], 16'hA501);
      chk("R13 record 2", mem[14'h222], 16'hA502);
      chk("R13 write count, no reads", (wr_cnt - w0) + 16 * (rd_cnt - r0), 3);
      chk("R13 end marker not written", mem[14'h2FF], 16'h0000);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] d;
      int r0, w0;
      mem[14'h205] = 16'h7777;
      setup(0, 'h05, 'h0);
      r0 = rd_cnt; w0 = wr_cnt;
      cfg_write(A_CTRL, 32'h1);
      cfg_write(A_DATA, 32'h9999);
      cfg_write(A_CTRL, 32'h5);
      wait_idle();
      chk("R5 ignored start adds no traffic", (wr_cnt - w0) + 16 * (rd_cnt - r0), 3);
      chk("R5 ignored direct target untouched", mem[14'h205], 16'h7777);
      rd_now(A_CTRL, d); chk("R5 no error from ignored start", d, 32'h4);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_direct_masked();
      t_direct_plain();
      t_error("R8", 12, 'h05, 32'h5, 32'h204);
      t_error("R9", 11, 'h05, 32'h5, 32'h204);
      t_error("R10", 3, 'h40, 32'h5, 32'h204);
      t_error("R11", 3, 'h05, 32'h9, 32'h208);
      t_err_clear();
      t_mif();
      t_busy_ignore();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule